// File: doc/BRIEF.md
# SIMT Divergence Stack Controller

This block tracks which lanes of an 8-lane SIMT pipeline are live for each of four warps. For every conditional branch it decides whether the live lanes agree. If they agree, the branch is an ordinary jump or fall-through. If they disagree, the warp splits: the not-taken lanes run first and the taken lanes wait on a per-warp divergence stack. A single join instruction, placed by the compiler at every post-dominator, later swaps to the waiting group or restores the original lanes. A branch that diverges again from the same PC while its entry is still in its first phase folds the departing lanes into that entry. A loop whose lanes exit one by one therefore occupies a single stack slot.

The pipeline sends one request per cycle: a branch resolve, a join, or an explicit split driven by a predicate. Each request carries the warp number, the current PC, a target PC and an 8-bit lane vector. One cycle later the block answers with the next PC and the warp's new active mask. The answer also carries a fault flag, a fault code and the faulting PC when the request cannot be honoured. A faulted warp stays halted until reset.

Top module: `simt_divctl`

## Requirements
- R1: After reset every warp has active mask 0xFF, an empty stack and no halt, and `rsp_valid` is low until a request is accepted.
- R2: A branch whose condition is set on every active lane answers, on the cycle after the request, with next PC equal to the target and an unchanged mask, and leaves the stack depth unchanged.
- R3: A branch whose condition is clear on every active lane answers with next PC equal to PC+1, modulo 4096, and an unchanged mask, without touching the stack.
- R4: Condition bits of inactive lanes never influence the taken, fall-through or split decision.
- R5: A branch with a mixed condition over active lanes pushes an entry. The entry holds saved mask = old active, pending = taken active lanes, target = branch target, source = PC and phase 0. The new mask is the not-taken active lanes and the next PC is PC+1.
- R6: A mixed branch whose PC equals the source PC of the top entry, while that entry is in phase 0, pushes nothing. It ORs the taken active lanes into that entry's pending mask and drops them from the active mask, so a loop consumes one entry.
- R7: A join on a phase-0 top entry whose target differs from the join PC and whose pending mask is non-zero makes the pending lanes active, redirects to the target and sets phase 1.
- R8: A join on a phase-0 top entry whose target equals the join PC, or whose pending mask is zero, pops the entry, restores its saved mask and answers PC+1.
- R9: A join on a phase-1 top entry pops it, restores its saved mask and answers PC+1.
- R10: A join on an empty stack changes nothing and answers PC+1 with the mask unchanged.
- R11: An explicit split keeps the active lanes whose predicate bit is set and pushes the rest as pending, with the given target. If no active lane keeps its bit, the block answers with fault code 9, next PC = PC and the faulting PC, and halts that warp.
- R12: A push attempted while the warp's stack holds DEPTH entries answers with fault code 10, next PC = PC and the faulting PC. It halts that warp and leaves its mask unchanged.
- R13: Each warp has its own mask and its own stack; a request for one warp never changes another warp.
- R14: A halted warp ignores every request. It answers with next PC = PC, its unchanged mask, no fault and `rsp_halted` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 none, 1 branch resolve, 2 join, 3 explicit split |
| req_warp | input | 2 | Warp addressed by the request |
| req_pc | input | 12 | PC of the instruction |
| req_target | input | 12 | Branch or split target PC |
| req_cond | input | 8 | Per-lane condition or predicate |
| rsp_valid | output | 1 | Response present |
| rsp_warp | output | 2 | Warp of the response |
| rsp_next_pc | output | 12 | PC the warp continues at |
| rsp_mask | output | 8 | Active mask after the request |
| rsp_fault | output | 1 | Request faulted |
| rsp_fault_code | output | 4 | 9 empty split, 10 stack full, else 0 |
| rsp_fault_pc | output | 12 | Faulting PC, 0 without a fault |
| rsp_halted | output | 1 | Warp is halted after the request |
| warp_halted | output | 4 | Halt state of every warp |

## Verification
The bench builds the block with the stack depth lowered to 4 and keeps 8 lanes, 4 warps and 12-bit PCs. With the shallow stack, four explicit splits fill one warp, so the overflow fault and the halted-warp behaviour are reached in a handful of requests. With four warps, one can be halted by each fault kind while two others keep running nested splits and folded loops, which shows that the warps stay isolated.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_BRANCH   = 2'd1,
    OP_CONVERGE = 2'd2,
    OP_DIVERGE  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    K_IDLE, K_TAKEN, K_FALL, K_SPLIT, K_FOLD,
    K_SWAP, K_POP, K_NOP, K_FAULT
  } kind_e;

  localparam logic [3:0] FAULT_EMPTY_SPLIT = 4'd9;
  localparam logic [3:0] FAULT_STACK_FULL  = 4'd10;

endpackage

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 41,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             upd_i,
  input  logic [ENT_W-1:0] wr_i,
  output logic [ENT_W-1:0] top_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] new_idx;

  assign top_idx = IDX_W'(depth_q - 1'b1);
  assign new_idx = IDX_W'(depth_q);
  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == FULL_CNT);
  assign depth_o = depth_q;
  assign top_o   = empty_o ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (push_i) begin
      depth_q <= depth_q + 1'b1;
    end else if (pop_i) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      mem[new_idx] <= wr_i;
    end else if (upd_i) begin
      mem[top_idx] <= wr_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R12
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i || upd_i) |-> !empty_o); // R8
  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_i, pop_i, upd_i})); // R5
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= FULL_CNT); // R12

endmodule

// File: rtl/simt_div_decide.sv
module simt_div_decide
  import simt_div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 12,
  localparam int ENT_W = 2 * LANES + 2 * PCW + 1
) (
  input  logic             valid_i,
  input  op_e              op_i,
  input  logic [PCW-1:0]   pc_i,
  input  logic [PCW-1:0]   target_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [LANES-1:0] active_i,
  input  logic             halted_i,
  input  logic [ENT_W-1:0] top_i,
  input  logic             empty_i,
  input  logic             full_i,
  output kind_e            kind_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             upd_o,
  output logic [ENT_W-1:0] wr_o,
  output logic [LANES-1:0] mask_o,
  output logic [PCW-1:0]   next_pc_o,
  output logic             fault_o,
  output logic [3:0]       code_o
);

  typedef struct packed {
    logic [LANES-1:0] saved;
    logic [LANES-1:0] pend;
    logic [PCW-1:0]   tgt;
    logic [PCW-1:0]   src;
    logic             phase;
  } ent_t;

  // lanes that would jump / stay, restricted to live lanes
  function automatic logic [LANES-1:0] lanes_set(input logic [LANES-1:0] act,
                                                 input logic [LANES-1:0] c);
    return act & c;
  endfunction

  function automatic logic [LANES-1:0] lanes_clear(input logic [LANES-1:0] act,
                                                   input logic [LANES-1:0] c);
    return act & ~c;
  endfunction

  function automatic logic [PCW-1:0] seq_pc(input logic [PCW-1:0] pc);
    return pc + PCW'(1);
  endfunction

  ent_t             top_e;
  ent_t             wr_e;
  logic [LANES-1:0] on_lanes;
  logic [LANES-1:0] off_lanes;
  logic             loop_hit;

  assign top_e     = ent_t'(top_i);
  assign on_lanes  = lanes_set(active_i, cond_i);
  assign off_lanes = lanes_clear(active_i, cond_i);
  assign loop_hit  = !empty_i && (top_e.src == pc_i) && !top_e.phase;
  assign wr_o      = wr_e;

  always_comb begin
    kind_o    = K_IDLE;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    upd_o     = 1'b0;
    wr_e      = top_e;
    mask_o    = active_i;
    next_pc_o = seq_pc(pc_i);
    fault_o   = 1'b0;
    code_o    = 4'd0;
    if (!valid_i || halted_i) begin
      next_pc_o = pc_i;
    end else begin
      unique case (op_i)
        OP_BRANCH: begin
          if (on_lanes == active_i) begin
            kind_o    = K_TAKEN;
            next_pc_o = target_i;
          end else if (on_lanes == '0) begin
            kind_o = K_FALL;
          end else if (loop_hit) begin
            kind_o     = K_FOLD;
            upd_o      = 1'b1;
            wr_e.pend  = top_e.pend | on_lanes;
            mask_o     = off_lanes;
          end else if (full_i) begin
            kind_o    = K_FAULT;
            fault_o   = 1'b1;
            code_o    = FAULT_STACK_FULL;
            next_pc_o = pc_i;
          end else begin
            kind_o = K_SPLIT;
            push_o = 1'b1;
            wr_e   = '{saved: active_i, pend: on_lanes, tgt: target_i,
                       src: pc_i, phase: 1'b0};
            mask_o = off_lanes;
          end
        end
        OP_DIVERGE: begin
          if (on_lanes == '0) begin
            kind_o    = K_FAULT;
            fault_o   = 1'b1;
            code_o    = FAULT_EMPTY_SPLIT;
            next_pc_o = pc_i;
          end else if (full_i) begin
            kind_o    = K_FAULT;
            fault_o   = 1'b1;
            code_o    = FAULT_STACK_FULL;
            next_pc_o = pc_i;
          end else begin
            kind_o = K_SPLIT;
            push_o = 1'b1;
            wr_e   = '{saved: active_i, pend: off_lanes, tgt: target_i,
                       src: pc_i, phase: 1'b0};
            mask_o = on_lanes;
          end
        end
        OP_CONVERGE: begin
          if (empty_i) begin
            kind_o = K_NOP;
          end else if (top_e.phase || top_e.tgt == pc_i || top_e.pend == '0) begin
            kind_o = K_POP;
            pop_o  = 1'b1;
            mask_o = top_e.saved;
          end else begin
            kind_o     = K_SWAP;
            upd_o      = 1'b1;
            wr_e.phase = 1'b1;
            mask_o     = top_e.pend;
            next_pc_o  = top_e.tgt;
          end
        end
        default: begin
          next_pc_o = pc_i;
        end
      endcase
    end
  end

endmodule

// File: rtl/simt_divctl.sv
module simt_divctl
  import simt_div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WARPS = 4,
  parameter int DEPTH = 16,
  parameter int PCW   = 12,
  localparam int WID_W = $clog2(WARPS),
  localparam int ENT_W = 2 * LANES + 2 * PCW + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [WID_W-1:0] req_warp,
  input  logic [PCW-1:0]   req_pc,
  input  logic [PCW-1:0]   req_target,
  input  logic [LANES-1:0] req_cond,
  output logic             rsp_valid,
  output logic [WID_W-1:0] rsp_warp,
  output logic [PCW-1:0]   rsp_next_pc,
  output logic [LANES-1:0] rsp_mask,
  output logic             rsp_fault,
  output logic [3:0]       rsp_fault_code,
  output logic [PCW-1:0]   rsp_fault_pc,
  output logic             rsp_halted,
  output logic [WARPS-1:0] warp_halted
);

  op_e              op;
  logic             fire;
  logic [LANES-1:0] mask_q [WARPS];
  logic [WARPS-1:0] halt_q;

  logic [ENT_W-1:0] top_all   [WARPS];
  logic [CNT_W-1:0] depth_all [WARPS];
  logic [WARPS-1:0] empty_all;
  logic [WARPS-1:0] full_all;
  logic [WARPS-1:0] sel_w;

  kind_e            dec_kind;
  logic             dec_push, dec_pop, dec_upd, dec_fault;
  logic [ENT_W-1:0] dec_wr;
  logic [LANES-1:0] dec_mask;
  logic [PCW-1:0]   dec_pc;
  logic [3:0]       dec_code;

  // named internal events for the checks below
  logic ev_uniform, ev_fold, ev_split, ev_join_nop;

  assign op   = op_e'(req_op);
  assign fire = req_valid && (op != OP_NONE);

  simt_div_decide #(.LANES(LANES), .PCW(PCW)) u_decide (
    .valid_i  (fire),
    .op_i     (op),
    .pc_i     (req_pc),
    .target_i (req_target),
    .cond_i   (req_cond),
    .active_i (mask_q[req_warp]),
    .halted_i (halt_q[req_warp]),
    .top_i    (top_all[req_warp]),
    .empty_i  (empty_all[req_warp]),
    .full_i   (full_all[req_warp]),
    .kind_o   (dec_kind),
    .push_o   (dec_push),
    .pop_o    (dec_pop),
    .upd_o    (dec_upd),
    .wr_o     (dec_wr),
    .mask_o   (dec_mask),
    .next_pc_o(dec_pc),
    .fault_o  (dec_fault),
    .code_o   (dec_code)
  );

  assign ev_uniform  = fire && (dec_kind == K_TAKEN || dec_kind == K_FALL);
  assign ev_fold     = fire && (dec_kind == K_FOLD);
  assign ev_split    = fire && (dec_kind == K_SPLIT);
  assign ev_join_nop = fire && (dec_kind == K_NOP);

  for (genvar w = 0; w < WARPS; w++) begin : g_warp
    assign sel_w[w] = fire && (req_warp == WID_W'(w));

    simt_div_stack #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (sel_w[w] && dec_push),
      .pop_i  (sel_w[w] && dec_pop),
      .upd_i  (sel_w[w] && dec_upd),
      .wr_i   (dec_wr),
      .top_o  (top_all[w]),
      .depth_o(depth_all[w]),
      .empty_o(empty_all[w]),
      .full_o (full_all[w])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[w] <= '1;
        halt_q[w] <= 1'b0;
      end else if (sel_w[w]) begin
        mask_q[w] <= dec_mask;
        halt_q[w] <= halt_q[w] | dec_fault;
      end
    end

    AST_LIVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !halt_q[w] |-> mask_q[w] != '0); // R11
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q[w] |=> halt_q[w]); // R14
  end

  assign warp_halted = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_warp       <= '0;
      rsp_next_pc    <= '0;
      rsp_mask       <= '0;
      rsp_fault      <= 1'b0;
      rsp_fault_code <= '0;
      rsp_fault_pc   <= '0;
      rsp_halted     <= 1'b0;
    end else begin
      rsp_valid      <= fire;
      rsp_warp       <= req_warp;
      rsp_next_pc    <= dec_pc;
      rsp_mask       <= dec_mask;
      rsp_fault      <= dec_fault;
      rsp_fault_code <= dec_code;
      rsp_fault_pc   <= dec_fault ? req_pc : '0;
      rsp_halted     <= halt_q[req_warp] | dec_fault;
    end
  end

  AST_UNIFORM_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uniform |=> depth_all[$past(req_warp)] == $past(depth_all[req_warp])); // R2
  AST_FOLD_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fold |=> depth_all[$past(req_warp)] == $past(depth_all[req_warp])); // R6
  AST_SPLIT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_split |=> depth_all[$past(req_warp)] == $past(depth_all[req_warp]) + 1'b1); // R5
  AST_JOIN_NOP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_join_nop |=> rsp_mask == $past(mask_q[req_warp])); // R10
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> warp_halted[rsp_warp]); // R11
  AST_SPLIT_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_split |=> (rsp_mask & ~$past(mask_q[req_warp])) == '0); // R5

endmodule

// File: tb/simt_divctl_test.sv
`timescale 1ns/1ps
module simt_divctl_test;

  localparam int LANES = 8;
  localparam int WARPS = 4;
  localparam int DEPTH = 4;
  localparam int PCW   = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_op = 2'd0;
  logic [1:0]       req_warp = 2'd0;
  logic [PCW-1:0]   req_pc = '0;
  logic [PCW-1:0]   req_target = '0;
  logic [LANES-1:0] req_cond = '0;
  logic             rsp_valid;
  logic [1:0]       rsp_warp;
  logic [PCW-1:0]   rsp_next_pc;
  logic [LANES-1:0] rsp_mask;
  logic             rsp_fault;
  logic [3:0]       rsp_fault_code;
  logic [PCW-1:0]   rsp_fault_pc;
  logic             rsp_halted;
  logic [WARPS-1:0] warp_halted;

  always #2 clk = ~clk;

  simt_divctl #(.LANES(LANES), .WARPS(WARPS), .DEPTH(DEPTH), .PCW(PCW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_warp(req_warp), .req_pc(req_pc), .req_target(req_target),
    .req_cond(req_cond), .rsp_valid(rsp_valid), .rsp_warp(rsp_warp),
    .rsp_next_pc(rsp_next_pc), .rsp_mask(rsp_mask), .rsp_fault(rsp_fault),
    .rsp_fault_code(rsp_fault_code), .rsp_fault_pc(rsp_fault_pc),
    .rsp_halted(rsp_halted), .warp_halted(warp_halted)
  );

  localparam logic [1:0] BR = 2'd1, JN = 2'd2, DV = 2'd3;

  typedef struct packed {
    logic [1:0]       warp;
    logic [PCW-1:0]   npc;
    logic [LANES-1:0] mask;
    logic             fault;
    logic [3:0]       code;
    logic [PCW-1:0]   fpc;
    logic             halted;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  task automatic issue(input logic [1:0] op, input logic [1:0] w,
                       input logic [PCW-1:0] pc, input logic [PCW-1:0] tgt,
                       input logic [LANES-1:0] cond, input logic [PCW-1:0] e_npc,
                       input logic [LANES-1:0] e_mask, input logic [3:0] e_code,
                       input logic e_halt, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    req_warp   = w;
    req_pc     = pc;
    req_target = tgt;
    req_cond   = cond;
    e.warp   = w;
    e.npc    = e_npc;
    e.mask   = e_mask;
    e.fault  = (e_code != 4'd0);
    e.code   = e_code;
    e.fpc    = (e_code != 4'd0) ? pc : '0;
    e.halted = e_halt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t  g;
      exp_t  e;
      string t;
      g = '{rsp_warp, rsp_next_pc, rsp_mask, rsp_fault, rsp_fault_code,
            rsp_fault_pc, rsp_halted};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected response: got %h expected none", g);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (g !== e) begin
          fails++;
          $display("FAIL %s: got w=%0d npc=%h mask=%h flt=%b code=%0d fpc=%h hlt=%b | exp w=%0d npc=%h mask=%h flt=%b code=%0d fpc=%h hlt=%b",
                   t, g.warp, g.npc, g.mask, g.fault, g.code, g.fpc, g.halted,
                   e.warp, e.npc, e.mask, e.fault, e.code, e.fpc, e.halted);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || warp_halted !== 4'b0000) begin
      fails++;
      $display("FAIL R1: got valid=%b halted=%b expected 0 and 0000", rsp_valid, warp_halted);
    end

    // warp 0: uniform paths, R1 reset mask seen as FF
    issue(BR, 0, 12'h010, 12'h020, 8'hFF, 12'h020, 8'hFF, 0, 0, "R2/R1 uniform taken");
    issue(BR, 0, 12'h020, 12'h030, 8'h00, 12'h021, 8'hFF, 0, 0, "R3 uniform fall");
    issue(BR, 0, 12'h021, 12'h040, 8'h0F, 12'h022, 8'hF0, 0, 0, "R5 split");
    issue(BR, 0, 12'h022, 12'h050, 8'h0F, 12'h023, 8'hF0, 0, 0, "R4 inactive-only true");
    issue(BR, 0, 12'h023, 12'h060, 8'hF3, 12'h060, 8'hF0, 0, 0, "R4 inactive bits ignored");
    issue(JN, 0, 12'h030, 12'h000, 8'h00, 12'h040, 8'h0F, 0, 0, "R7 swap");
    issue(JN, 0, 12'h030, 12'h000, 8'h00, 12'h031, 8'hFF, 0, 0, "R9 phase1 pop");
    issue(JN, 0, 12'h031, 12'h000, 8'h00, 12'h032, 8'hFF, 0, 0, "R10 empty nop");
    // loop folding
    issue(BR, 0, 12'h042, 12'h080, 8'h01, 12'h043, 8'hFE, 0, 0, "R5 loop first");
    issue(BR, 0, 12'h042, 12'h080, 8'h03, 12'h043, 8'hFC, 0, 0, "R6 fold");
    issue(BR, 0, 12'h042, 12'h080, 8'h0C, 12'h043, 8'hF0, 0, 0, "R6 fold again");
    issue(JN, 0, 12'h080, 12'h000, 8'h00, 12'h081, 8'hFF, 0, 0, "R8 target==pc pop");
    issue(JN, 0, 12'h081, 12'h000, 8'h00, 12'h082, 8'hFF, 0, 0, "R6 one entry used");
    issue(BR, 0, 12'h100, 12'h200, 8'h81, 12'h101, 8'h7E, 0, 0, "R5 split");
    issue(BR, 0, 12'h100, 12'h200, 8'h02, 12'h101, 8'h7C, 0, 0, "R6 fold");
    issue(JN, 0, 12'h150, 12'h000, 8'h00, 12'h200, 8'h83, 0, 0, "R6/R7 pending merged");
    issue(JN, 0, 12'h150, 12'h000, 8'h00, 12'h151, 8'hFF, 0, 0, "R9 restore");
    // nesting, different source: no fold
    issue(BR, 0, 12'h300, 12'h310, 8'h0F, 12'h301, 8'hF0, 0, 0, "R5 outer");
    issue(BR, 0, 12'h301, 12'h320, 8'h30, 12'h302, 8'hC0, 0, 0, "R5 inner push");
    issue(JN, 0, 12'h320, 12'h000, 8'h00, 12'h321, 8'hF0, 0, 0, "R8 inner pop");
    issue(JN, 0, 12'h310, 12'h000, 8'h00, 12'h311, 8'hFF, 0, 0, "R8 outer pop");
    // warp 1: fill and overflow
    issue(DV, 1, 12'h400, 12'h500, 8'h7F, 12'h401, 8'h7F, 0, 0, "R11 split 1");
    issue(DV, 1, 12'h401, 12'h500, 8'h3F, 12'h402, 8'h3F, 0, 0, "R11 split 2");
    issue(DV, 1, 12'h402, 12'h500, 8'h1F, 12'h403, 8'h1F, 0, 0, "R11 split 3");
    issue(DV, 1, 12'h403, 12'h500, 8'h0F, 12'h404, 8'h0F, 0, 0, "R11 split 4");
    issue(BR, 1, 12'h404, 12'h600, 8'h03, 12'h404, 8'h0F, 4'd10, 1, "R12 overflow");
    issue(BR, 1, 12'h405, 12'h600, 8'hFF, 12'h405, 8'h0F, 0, 1, "R14 halted ignore");
    // independence
    issue(BR, 2, 12'h010, 12'h020, 8'h00, 12'h011, 8'hFF, 0, 0, "R13 warp2 untouched");
    issue(JN, 0, 12'h700, 12'h000, 8'h00, 12'h701, 8'hFF, 0, 0, "R13 warp0 untouched");
    // warp 3: empty explicit split
    issue(BR, 3, 12'h010, 12'h020, 8'h0F, 12'h011, 8'hF0, 0, 0, "R5 warp3 split");
    issue(DV, 3, 12'h011, 12'h030, 8'h0F, 12'h011, 8'hF0, 4'd9, 1, "R11 empty split fault");
    issue(JN, 3, 12'h012, 12'h000, 8'h00, 12'h012, 8'hF0, 0, 1, "R14 halted join");
    // warp 2: zero pending
    issue(DV, 2, 12'h020, 12'h040, 8'hFF, 12'h021, 8'hFF, 0, 0, "R11 full predicate");
    issue(JN, 2, 12'h030, 12'h000, 8'h00, 12'h031, 8'hFF, 0, 0, "R8 zero pending pop");
    issue(JN, 2, 12'h031, 12'h000, 8'h00, 12'h032, 8'hFF, 0, 0, "R10 empty after pop");
    issue(BR, 2, 12'hFFF, 12'h020, 8'h00, 12'h000, 8'hFF, 0, 0, "R3 pc wrap");

    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 2'd0;
    repeat (4) @(negedge clk);
    checks++;
    if (warp_halted !== 4'b1010) begin
      fails++;
      $display("FAIL R12/R11: got halted=%b expected 1010", warp_halted);
    end
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule